// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator processor. Each clock it takes an accumulator byte, a second operand byte, a four-bit operation code and the current six-bit status word. One clock edge later it presents the result byte and the updated status word. The operations are the three bitwise functions and add with carry. It also does subtract with borrow, compare, bit test, two shifts, two rotates, increment and decrement.

The surrounding core routes the correct byte onto `opnd_i`. For an accumulator-form shift or increment, that byte is the accumulator; for a memory form, it is the fetched data. The core then writes back `result_q` wherever it belongs. The decimal and interrupt-disable flags pass straight through the block. The decimal flag never changes the arithmetic.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `result_q` and `flags_q` are zero, whatever the other inputs are.
- R2: The status word is {N,V,D,I,Z,C} with N at bit 5, V at bit 4, D at bit 3, I at bit 2, Z at bit 1 and C at bit 0. Results and flags appear on the outputs at the clock edge that follows the inputs, and not before it.
- R3: Every operation that updates N and Z takes N from result bit 7 and sets Z exactly when the result byte is zero. These operations are codes 0 to 4 and 7 to 12.
- R4: Code 0 is OR, code 1 is AND and code 2 is XOR of `acc_i` with `opnd_i`. C and V are left unchanged.
- R5: Code 3 (add) computes acc + opnd + C. C becomes bit 8 of the sum. V is the carry into bit 7 XOR the carry out of bit 7.
- R6: Code 4 (subtract) computes acc + (ones complement of opnd) + C. C and V follow the R5 rules, so C=1 means no borrow.
- R7: Code 5 (compare) forms acc − opnd. C is set when acc ≥ opnd, and N and Z come from the 8-bit difference. V is unchanged, and `result_q` equals `acc_i`.
- R8: Code 6 (bit test) copies opnd bits 7 and 6 into N and V, and sets Z only when (acc AND opnd) is zero. C is unchanged and `result_q` equals `acc_i`.
- R9: Codes 7 to 10 act on `opnd_i`. Code 7 shifts left, moving bit 7 into C and a 0 into bit 0. Code 8 shifts right, moving bit 0 into C and a 0 into bit 7. Code 9 rotates left, moving old C into bit 0 and bit 7 into C. Code 10 rotates right, moving old C into bit 7 and bit 0 into C. V is unchanged.
- R10: Code 11 increments and code 12 decrements `opnd_i` modulo 256. Only N and Z change.
- R11: D and I are copied from `flags_i` unchanged by every operation. A set D does not alter any result.
- R12: Codes 13 to 15 return `acc_i` and copy `flags_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | DATA_W | Accumulator byte |
| opnd_i | input | DATA_W | Second operand byte |
| flags_i | input | 6 | Incoming status word {N,V,D,I,Z,C} |
| result_q | output | DATA_W | Registered result |
| flags_q | output | 6 | Registered status word |

## Verification
The bench builds the block with DATA_W = 8. At that width the shared adder can be swept over all 256×256 operand pairs with both carry values, so every carry chain and every overflow corner of add is reached. Subtract and compare use the same adder with an inverted operand. The bench covers them with a strided sweep over all codes and two flag patterns. A table of hand-computed cases targets the wrap, zero, sign and carry-in edges of each operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int FLAG_W = 6;

    typedef enum logic [3:0] {
        OP_OR  = 4'd0,
        OP_AND = 4'd1,
        OP_XOR = 4'd2,
        OP_ADC = 4'd3,
        OP_SBC = 4'd4,
        OP_CMP = 4'd5,
        OP_BIT = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10,
        OP_INC = 4'd11,
        OP_DEC = 4'd12
    } alu_op_e;

    // status word, bit 5 down to bit 0
    typedef struct packed {
        logic neg;
        logic ovf;
        logic dec;
        logic irq;
        logic zero;
        logic carry;
    } flags_t;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         c_msb_o,
    output logic         cout_o
);
    logic [W-1:0] low_sum;
    logic [W:0]   full_sum;

    // carry into the top bit comes from the sum of the lower W-1 bits
    assign low_sum  = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]} + {{(W-1){1'b0}}, cin_i};
    assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};

    assign c_msb_o = low_sum[W-1];
    assign sum_o   = full_sum[W-1:0];
    assign cout_o  = full_sum[W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] or_o,
    output logic [W-1:0] and_o,
    output logic [W-1:0] xor_o
);
    assign or_o  = a_i | b_i;
    assign and_o = a_i & b_i;
    assign xor_o = a_i ^ b_i;
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   kind_i,
    input  logic [W-1:0] v_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    always_comb begin
        res_o  = v_i;
        cout_o = cin_i;
        case (kind_i)
            OP_SHL: {cout_o, res_o} = {v_i, 1'b0};
            OP_SHR: {res_o, cout_o} = {1'b0, v_i};
            OP_ROL: {cout_o, res_o} = {v_i, cin_i};
            OP_ROR: {res_o, cout_o} = {cin_i, v_i};
            OP_INC: res_o = v_i + W'(1);
            OP_DEC: res_o = v_i - W'(1);
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [5:0]        flags_i,
    output logic [DATA_W-1:0] result_q,
    output logic [5:0]        flags_q
);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            flg;
    } stage_t;

    stage_t state_d, state_q;
    flags_t fin;

    logic [DATA_W-1:0] add_b, add_sum, or_v, and_v, xor_v, sh_res;
    logic              add_cin, add_cmsb, add_cout, sh_cout;

    assign fin = flags_t'(flags_i);

    // operand steering for the shared adder
    always_comb begin
        add_b   = opnd_i;
        add_cin = fin.carry;
        if (op_i == OP_SBC || op_i == OP_CMP) add_b = ~opnd_i;
        if (op_i == OP_CMP) add_cin = 1'b1;
    end

    acc_alu_adder #(.W(DATA_W)) u_add (
        .a_i    (acc_i),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sum_o  (add_sum),
        .c_msb_o(add_cmsb),
        .cout_o (add_cout)
    );

    acc_alu_logic #(.W(DATA_W)) u_log (
        .a_i  (acc_i),
        .b_i  (opnd_i),
        .or_o (or_v),
        .and_o(and_v),
        .xor_o(xor_v)
    );

    acc_alu_shift #(.W(DATA_W)) u_sh (
        .kind_i(op_i),
        .v_i   (opnd_i),
        .cin_i (fin.carry),
        .res_o (sh_res),
        .cout_o(sh_cout)
    );

    always_comb begin
        logic upd_nz;
        state_d.res = acc_i;
        state_d.flg = fin;
        upd_nz      = 1'b0;
        case (op_i)
            OP_OR:  begin state_d.res = or_v;  upd_nz = 1'b1; end
            OP_AND: begin state_d.res = and_v; upd_nz = 1'b1; end
            OP_XOR: begin state_d.res = xor_v; upd_nz = 1'b1; end
            OP_ADC, OP_SBC: begin
                state_d.res       = add_sum;
                state_d.flg.carry = add_cout;
                state_d.flg.ovf   = add_cout ^ add_cmsb;
                upd_nz            = 1'b1;
            end
            OP_CMP: begin
                state_d.flg.carry = add_cout;
                state_d.flg.neg   = add_sum[MSB];
                state_d.flg.zero  = (add_sum == '0);
            end
            OP_BIT: begin
                state_d.flg.neg  = opnd_i[MSB];
                state_d.flg.ovf  = opnd_i[MSB-1];
                state_d.flg.zero = (and_v == '0);
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                state_d.res       = sh_res;
                state_d.flg.carry = sh_cout;
                upd_nz            = 1'b1;
            end
            OP_INC, OP_DEC: begin
                state_d.res = sh_res;
                upd_nz      = 1'b1;
            end
            default: ;
        endcase
        if (upd_nz) begin
            state_d.flg.neg  = state_d.res[MSB];
            state_d.flg.zero = (state_d.res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result_q = state_q.res;
    assign flags_q  = state_q.flg;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [5:0]        flags_i,
    input logic [DATA_W-1:0] result_q,
    input logic [5:0]        flags_q
);
    logic primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    AST_NZ_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(op_i) <= OP_DEC && $past(op_i) != OP_CMP && $past(op_i) != OP_BIT
        |-> flags_q[5] == result_q[DATA_W-1] && flags_q[1] == (result_q == '0)); // R3

    AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(op_i) <= OP_XOR
        |-> flags_q[4] == $past(flags_i[4]) && flags_q[0] == $past(flags_i[0])); // R4

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(op_i) == OP_CMP
        |-> result_q == $past(acc_i) && flags_q[4] == $past(flags_i[4])); // R7

    AST_BIT_COPIES_NV: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(op_i) == OP_BIT
        |-> flags_q[5:4] == $past(opnd_i[DATA_W-1:DATA_W-2]) && result_q == $past(acc_i)); // R8

    AST_INCDEC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)
        |-> flags_q[4] == $past(flags_i[4]) && flags_q[0] == $past(flags_i[0])); // R10

    AST_DI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> flags_q[3:2] == $past(flags_i[3:2])); // R11

    AST_IDLE_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q && $past(op_i) > OP_DEC
        |-> result_q == $past(acc_i) && flags_q == $past(flags_i)); // R12
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_i    (op_i),
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .flags_i (flags_i),
    .result_q(result_q),
    .flags_q (flags_q)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [5:0] flags_i = '0;
    logic [7:0] result_q;
    logic [5:0] flags_q;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    acc_alu #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_i(acc_i),
        .opnd_i(opnd_i), .flags_i(flags_i), .result_q(result_q), .flags_q(flags_q)
    );

    // {op, acc, opnd, flags_in, exp_result, exp_flags}; flags = {N,V,D,I,Z,C}
    localparam int NV = 18;
    localparam logic [39:0] VECS [NV] = '{
        {4'd0,  8'h0F, 8'hF0, 6'h11, 8'hFF, 6'h31},  // R4 OR keeps V,C
        {4'd1,  8'h0F, 8'hF0, 6'h0C, 8'h00, 6'h0E},  // R4 AND zero
        {4'd2,  8'hAA, 8'hAA, 6'h08, 8'h00, 6'h0A},  // R4 XOR zero
        {4'd3,  8'h50, 8'h50, 6'h00, 8'hA0, 6'h30},  // R5 signed overflow
        {4'd3,  8'hFF, 8'h01, 6'h00, 8'h00, 6'h03},  // R5 wrap with carry out
        {4'd4,  8'h50, 8'hF0, 6'h01, 8'h60, 6'h00},  // R6 borrow, no overflow
        {4'd4,  8'h50, 8'hB0, 6'h01, 8'hA0, 6'h30},  // R6 overflow
        {4'd5,  8'h40, 8'h40, 6'h10, 8'h40, 6'h13},  // R7 equal keeps V
        {4'd5,  8'h10, 8'h20, 6'h01, 8'h10, 6'h20},  // R7 less than
        {4'd6,  8'h0F, 8'hC0, 6'h00, 8'h0F, 6'h32},  // R8 bit test
        {4'd7,  8'h77, 8'h81, 6'h00, 8'h02, 6'h01},  // R9 shift left
        {4'd8,  8'h77, 8'h01, 6'h20, 8'h00, 6'h03},  // R9 shift right
        {4'd9,  8'h77, 8'h80, 6'h01, 8'h01, 6'h01},  // R9 rotate left
        {4'd10, 8'h77, 8'h01, 6'h01, 8'h80, 6'h21},  // R9 rotate right
        {4'd11, 8'h77, 8'hFF, 6'h11, 8'h00, 6'h13},  // R10 increment wrap
        {4'd12, 8'h77, 8'h00, 6'h00, 8'hFF, 6'h20},  // R10 decrement wrap
        {4'd3,  8'h09, 8'h01, 6'h08, 8'h0A, 6'h08},  // R11 D set, binary sum
        {4'd13, 8'h5A, 8'h00, 6'h3F, 8'h5A, 6'h3F}   // R12 idle code
    };

    function automatic logic [13:0] ref_model(logic [3:0] op, logic [7:0] a, logic [7:0] m, logic [5:0] f);
        logic [7:0] r;
        logic [7:0] d8;
        logic [5:0] o;
        logic       nz;
        int         s;
        r = a; o = f; nz = 1'b0;
        case (op)
            4'd0: begin r = a | m; nz = 1'b1; end
            4'd1: begin r = a & m; nz = 1'b1; end
            4'd2: begin r = a ^ m; nz = 1'b1; end
            4'd3: begin
                s = int'(a) + int'(m) + int'(f[0]);
                r = 8'(s); o[0] = (s > 255);
                o[4] = (a[7] == m[7]) && (r[7] != a[7]); nz = 1'b1;
            end
            4'd4: begin
                s = int'(a) - int'(m) - (f[0] ? 0 : 1);
                r = 8'(s); o[0] = (s >= 0);
                o[4] = (a[7] != m[7]) && (r[7] != a[7]); nz = 1'b1;
            end
            4'd5: begin
                s = int'(a) - int'(m); d8 = 8'(s);
                o[0] = (a >= m); o[5] = d8[7]; o[1] = (d8 == 8'h00);
            end
            4'd6: begin o[5] = m[7]; o[4] = m[6]; o[1] = ((a & m) == 8'h00); end
            4'd7: begin o[0] = m[7]; r = {m[6:0], 1'b0}; nz = 1'b1; end
            4'd8: begin o[0] = m[0]; r = {1'b0, m[7:1]}; nz = 1'b1; end
            4'd9: begin o[0] = m[7]; r = {m[6:0], f[0]}; nz = 1'b1; end
            4'd10: begin o[0] = m[0]; r = {f[0], m[7:1]}; nz = 1'b1; end
            4'd11: begin r = m + 8'd1; nz = 1'b1; end
            4'd12: begin r = m - 8'd1; nz = 1'b1; end
            default: ;
        endcase
        if (nz) begin o[5] = r[7]; o[1] = (r == 8'h00); end
        return {r, o};
    endfunction

    task automatic check(input string what, input logic [13:0] exp);
        n_tests++;
        if ({result_q, flags_q} !== exp) begin
            n_fail++;
            $display("FAIL %s: got res=%h flags=%b, expected res=%h flags=%b",
                     what, result_q, flags_q, exp[13:6], exp[5:0]);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m, input logic [5:0] f);
        op_i = op; acc_i = a; opnd_i = m; flags_i = f;
    endtask

    // call at a falling edge; checks at the next falling edge
    task automatic step(input logic [3:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic [5:0] f, input logic [13:0] exp, input string what);
        drive(op, a, m, f);
        @(negedge clk);
        check(what, exp);
    endtask

    initial begin
        // R1: reset holds outputs at zero despite active inputs
        drive(4'd3, 8'hFF, 8'hFF, 6'h3F);
        repeat (3) @(negedge clk);
        check("R1 reset state", 14'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][39:36], VECS[i][35:28], VECS[i][27:20], VECS[i][19:14],
                 VECS[i][13:0], $sformatf("table entry %0d", i));
        end

        // R2: output changes only at the following clock edge
        drive(4'd0, 8'h3C, 8'h00, 6'h00);
        #5;
        check("R2 before edge", {8'h5A, 6'h3F});
        @(negedge clk);
        check("R2 after edge", {8'h3C, 6'h00});

        // R5: every operand pair, both carry values
        for (int a = 0; a < 256; a++) begin
            for (int m = 0; m < 256; m++) begin
                for (int c = 0; c < 2; c++) begin
                    step(4'd3, 8'(a), 8'(m), {5'b0, 1'(c)},
                         ref_model(4'd3, 8'(a), 8'(m), {5'b0, 1'(c)}), "R5 add sweep");
                end
            end
        end

        // R3 R6 R7 R8 R9 R10 R11 R12: strided sweep of all codes
        for (int a = 0; a < 256; a += 37) begin
            for (int m = 0; m < 256; m += 41) begin
                for (int op = 0; op < 16; op++) begin
                    for (int fp = 0; fp < 2; fp++) begin
                        logic [5:0] fv;
                        fv = fp ? 6'h3F : 6'h0A;
                        step(4'(op), 8'(a), 8'(m), fv, ref_model(4'(op), 8'(a), 8'(m), fv),
                             $sformatf("R3 sweep op %0d", op));
                    end
                end
            end
        end

        // R1: asynchronous reset mid-run clears outputs
        step(4'd0, 8'h80, 8'h00, 6'h00, {8'h80, 6'h20}, "R3 before reset");
        rst_n = 1'b0;
        #1;
        check("R1 mid-run reset", 14'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule